// File: doc/BRIEF.md
# Banked Edge-Triggered External Interrupt Controller

This block watches a set of asynchronous external lines, brings each one into the system clock domain, and turns selected transitions into sticky pending flags. The lines are grouped in banks of 32. Each bank has its own configuration and status words on a 32-bit register bus. Each bank drives one interrupt request. Every line also has an event output that pulses for one cycle.

Each line picks its active edge with two independent enables, one for rising and one for falling. Both enables may be set, in which case either transition is caught. Software can also raise a pending flag directly. It acknowledges a line by writing a one to that line's pending bit. Which lines exist in each bank is fixed by a per-bank availability parameter. Bits of absent lines hold zero, so writing all ones to a configuration word and reading it back shows which lines are present.

Bank words sit in two separate windows of the address map. The edge-enable and software-trigger words of bank `b` start at `b*0x20`. The mask and pending words start at `0x80 + b*0x10`.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After a synchronous reset, every register reads zero, every interrupt request is low and every event output is low.
- R2: Bank `b` decodes its words at these byte addresses:
  - rising-enable at `b*0x20`
  - falling-enable at `b*0x20+0x04`
  - software trigger at `b*0x20+0x08`
  - interrupt mask at `0x80+b*0x10`
  - event mask at `0x80+b*0x10+0x04`
  - pending at `0x80+b*0x10+0x08`

  Read data is registered and appears one cycle after the address is presented.
- R3: In every word, bits of lines absent from the bank's availability mask ignore writes and read zero. Writing all ones to an enable word and reading it back returns that mask. A software trigger on an absent line sets nothing.
- R4: Take a line whose rising enable is set and whose input goes from 0 to 1. Its pending bit becomes 1 at the third clock edge after the change: two synchronizer stages, then the pending flop.
- R5: A line whose falling enable is set latches a 1-to-0 transition in the same way. A line with both enables set latches either transition.
- R6: A transition on a line whose matching enable is clear leaves that line's pending bit unchanged.
- R7: Writing a pending word clears each bit written as 1. Bits written as 0 stay as they were, and other lines' pending bits are unaffected.
- R8: Writing 1 to a software-trigger bit sets that line's pending bit. Writing 0 has no effect. The software-trigger word always reads zero.
- R9: A bank's interrupt request is the registered OR, over its lines, of pending AND interrupt mask. It follows the pending state one cycle later.
- R10: An enabled edge on a line whose event-mask bit is set produces exactly one single-cycle pulse on that line's event output. A line with its event-mask bit clear, or a software trigger, produces no pulse.
- R11: Reads of any address not listed in R2 return zero. This includes addresses that are not word aligned and addresses of banks beyond the configured count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_in | input | NBANK*32 | Asynchronous external lines, bank `b` in bits `b*32+31 : b*32` |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | NBANK | Interrupt request per bank |
| evt_o | output | NBANK*32 | Single-cycle event pulse per line |

## Verification
The bench builds three banks. Bank 0 is fully populated. Bank 1 lacks lines 12 to 15. Bank 2 implements only lines 0 to 22. This puts holes both inside a word and at its top, so probing by readback, ignored writes and dead software triggers are all exercised. With three banks, the fourth bank slot in each address window is unmapped. Reads of those addresses must return zero, and the bank index decode is tested at the edge of the configured count.

// File: rtl/eirq_pkg.sv
`timescale 1ns/1ps
package eirq_pkg;
  localparam int LINES   = 32;
  localparam int ADDR_W  = 8;
  localparam int BIDX_W  = 2;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RISE,
    SEL_FALL,
    SEL_SWT,
    SEL_IMSK,
    SEL_EMSK,
    SEL_PEND
  } word_sel_e;
endpackage

// File: rtl/eirq_sync.sv
`timescale 1ns/1ps
module eirq_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise = sync_q & ~prev_q;
  assign fall = ~sync_q & prev_q;
endmodule

// File: rtl/eirq_decode.sv
`timescale 1ns/1ps
module eirq_decode
  import eirq_pkg::*;
#(
  parameter int NBANK = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BIDX_W-1:0] bank,
  output word_sel_e         sel,
  output logic              hit
);
  word_sel_e raw_sel;

  always_comb begin
    raw_sel = SEL_NONE;
    bank    = '0;
    if (addr[1:0] == 2'b00) begin
      if (!addr[7]) begin
        bank = addr[6:5];
        case (addr[4:2])
          3'd0:    raw_sel = SEL_RISE;
          3'd1:    raw_sel = SEL_FALL;
          3'd2:    raw_sel = SEL_SWT;
          default: raw_sel = SEL_NONE;
        endcase
      end else if (!addr[6]) begin
        bank = addr[5:4];
        case (addr[3:2])
          2'd0:    raw_sel = SEL_IMSK;
          2'd1:    raw_sel = SEL_EMSK;
          2'd2:    raw_sel = SEL_PEND;
          default: raw_sel = SEL_NONE;
        endcase
      end
    end
    hit = (raw_sel != SEL_NONE) && (int'(bank) < NBANK);
    sel = hit ? raw_sel : SEL_NONE;
  end
endmodule

// File: rtl/eirq_bank.sv
`timescale 1ns/1ps
module eirq_bank
  import eirq_pkg::*;
#(
  parameter int           W     = 32,
  parameter logic [W-1:0] AVAIL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  word_sel_e    sel,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] rise,
  input  logic [W-1:0] fall,
  output logic [W-1:0] rd_data,
  output logic         irq_o,
  output logic [W-1:0] evt_o
);
  logic [W-1:0] rise_en_q, fall_en_q, imsk_q, emsk_q, pend_q;
  logic [W-1:0] sw_set, clr, hit, pend_d, wmask;
  logic         ok_q;

  always_comb begin
    wmask   = wdata & AVAIL;
    sw_set  = (wr_en && sel == SEL_SWT)  ? wmask : '0;
    clr     = (wr_en && sel == SEL_PEND) ? wdata : '0;
    hit     = (rise & rise_en_q) | (fall & fall_en_q);
    pend_d  = (pend_q & ~clr) | ((hit | sw_set) & AVAIL);
  end

  always_comb begin
    case (sel)
      SEL_RISE: rd_data = rise_en_q;
      SEL_FALL: rd_data = fall_en_q;
      SEL_IMSK: rd_data = imsk_q;
      SEL_EMSK: rd_data = emsk_q;
      SEL_PEND: rd_data = pend_q;
      default:  rd_data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_en_q <= '0;
      fall_en_q <= '0;
      imsk_q    <= '0;
      emsk_q    <= '0;
      pend_q    <= '0;
      irq_o     <= 1'b0;
      evt_o     <= '0;
      ok_q      <= 1'b0;
    end else begin
      ok_q <= 1'b1;
      if (wr_en) begin
        case (sel)
          SEL_RISE: rise_en_q <= wmask;
          SEL_FALL: fall_en_q <= wmask;
          SEL_IMSK: imsk_q    <= wmask;
          SEL_EMSK: emsk_q    <= wmask;
          default:  ;
        endcase
      end
      pend_q <= pend_d;
      evt_o  <= hit & emsk_q;
      irq_o  <= |(pend_q & imsk_q);
    end
  end

  // R7: a pending bit only drops in the cycle after a one was written to it
  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    ok_q |-> (($past(pend_q) & ~$past(clr) & ~pend_q) == '0));

  // R8: a software trigger leaves its available bits pending
  p_swt_sets_r8: assert property (@(posedge clk) disable iff (rst)
    (ok_q && $past(wr_en && sel == SEL_SWT)) |->
      ((pend_q & $past(wdata) & AVAIL) == ($past(wdata) & AVAIL)));

  // R9: request follows masked pending one cycle later
  p_irq_follow_r9: assert property (@(posedge clk) disable iff (rst)
    ok_q |-> (irq_o == |($past(pend_q) & $past(imsk_q))));

  // R10: no event pulse on a line whose event mask was clear
  p_evt_masked_r10: assert property (@(posedge clk) disable iff (rst)
    ok_q |-> ((evt_o & ~$past(emsk_q)) == '0));

  // R3: absent lines never become pending
  p_absent_idle_r3: assert property (@(posedge clk) disable iff (rst)
    ((pend_q | evt_o) & ~AVAIL) == '0);
endmodule

// File: rtl/edge_irq_ctrl.sv
`timescale 1ns/1ps
module edge_irq_ctrl
  import eirq_pkg::*;
#(
  parameter int                    NBANK      = 3,
  parameter logic [NBANK*32-1:0]   AVAIL_MASK = '1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NBANK*32-1:0]   ext_in,
  input  logic [7:0]            bus_addr,
  input  logic                  bus_we,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic [NBANK-1:0]      irq_o,
  output logic [NBANK*32-1:0]   evt_o
);
  localparam int NL = NBANK * LINES;

  logic [BIDX_W-1:0] dec_bank;
  word_sel_e         dec_sel;
  logic              dec_hit;
  logic [NL-1:0]     rise_all, fall_all;
  logic [31:0]       bank_rd [NBANK];
  logic [31:0]       rd_mux;
  logic              ok_q;

  eirq_decode #(.NBANK(NBANK)) u_decode (
    .addr (bus_addr),
    .bank (dec_bank),
    .sel  (dec_sel),
    .hit  (dec_hit)
  );

  eirq_sync #(.W(NL)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (ext_in),
    .rise (rise_all),
    .fall (fall_all)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic bank_wr;
    assign bank_wr = bus_we && dec_hit && (int'(dec_bank) == b);

    eirq_bank #(
      .W     (LINES),
      .AVAIL (AVAIL_MASK[b*LINES +: LINES])
    ) u_bank (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (bank_wr),
      .sel     (dec_sel),
      .wdata   (bus_wdata),
      .rise    (rise_all[b*LINES +: LINES]),
      .fall    (fall_all[b*LINES +: LINES]),
      .rd_data (bank_rd[b]),
      .irq_o   (irq_o[b]),
      .evt_o   (evt_o[b*LINES +: LINES])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (dec_hit && int'(dec_bank) == b) rd_mux = bank_rd[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      ok_q      <= 1'b0;
    end else begin
      bus_rdata <= rd_mux;
      ok_q      <= 1'b1;
    end
  end

  // R11: an unmapped address returns zero on the following cycle
  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (ok_q && !$past(dec_hit)) |-> (bus_rdata == '0));
endmodule

// File: tb/edge_irq_ctrl_bench.sv
`timescale 1ns/1ps
module edge_irq_ctrl_bench;
  localparam int NB = 3;
  localparam logic [NB*32-1:0] AV = {32'h007F_FFFF, 32'hFFFF_0FFF, 32'hFFFF_FFFF};

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NB*32-1:0] ext_in = '0;
  logic [7:0]      bus_addr = '0;
  logic            bus_we = 1'b0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NB-1:0]   irq_o;
  logic [NB*32-1:0] evt_o;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  logic [31:0] m_rise [NB], m_fall [NB], m_imsk [NB], m_emsk [NB], m_pend [NB];
  int ev_exp [NB];
  int ev_act [NB];

  always #2.5 clk = ~clk;

  edge_irq_ctrl #(.NBANK(NB), .AVAIL_MASK(AV)) u_edge_irq_ctrl (
    .clk(clk), .rst(rst), .ext_in(ext_in), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o), .evt_o(evt_o)
  );

  function automatic logic [31:0] avail(int b);
    return AV[b*32 +: 32];
  endfunction
  function automatic logic [7:0] a_rise(int b); return 8'(b*32);          endfunction
  function automatic logic [7:0] a_fall(int b); return 8'(b*32 + 4);      endfunction
  function automatic logic [7:0] a_swt(int b);  return 8'(b*32 + 8);      endfunction
  function automatic logic [7:0] a_imsk(int b); return 8'(128 + b*16);    endfunction
  function automatic logic [7:0] a_emsk(int b); return 8'(128 + b*16 + 4); endfunction
  function automatic logic [7:0] a_pend(int b); return 8'(128 + b*16 + 8); endfunction

  always @(negedge clk) begin
    if (!rst) begin
      for (int b = 0; b < NB; b++) ev_act[b] += $countones(evt_o[b*32 +: 32]);
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    bus_we   = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
    for (int b = 0; b < NB; b++) begin
      if (a == a_rise(b)) m_rise[b] = d & avail(b);
      if (a == a_fall(b)) m_fall[b] = d & avail(b);
      if (a == a_imsk(b)) m_imsk[b] = d & avail(b);
      if (a == a_emsk(b)) m_emsk[b] = d & avail(b);
      if (a == a_swt(b))  m_pend[b] |= d & avail(b);
      if (a == a_pend(b)) m_pend[b] &= ~d;
    end
  endtask

  task automatic drive(input logic [NB*32-1:0] nv);
    @(negedge clk);
    for (int b = 0; b < NB; b++) begin
      logic [31:0] o, n, h;
      o = ext_in[b*32 +: 32];
      n = nv[b*32 +: 32];
      h = ((n & ~o) & m_rise[b]) | ((o & ~n) & m_fall[b]);
      m_pend[b] |= h;
      ev_exp[b] += $countones(h & m_emsk[b]);
    end
    ext_in = nv;
    repeat (5) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    logic [31:0] d;
    repeat (2) @(negedge clk);
    for (int b = 0; b < NB; b++) begin
      rd(a_pend(b), d);
      chk({tag, " pending"}, d, m_pend[b]);
      chk({tag, " R9 irq"}, {31'd0, irq_o[b]}, {31'd0, |(m_pend[b] & m_imsk[b])});
      chk({tag, " R10 events"}, 32'(ev_act[b]), 32'(ev_exp[b]));
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [NB*32-1:0] v;
    int unused_seed;
    unused_seed = $urandom(32'd1234);
    for (int b = 0; b < NB; b++) begin
      m_rise[b] = 0; m_fall[b] = 0; m_imsk[b] = 0; m_emsk[b] = 0; m_pend[b] = 0;
      ev_exp[b] = 0; ev_act[b] = 0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state of every word and output
    for (int b = 0; b < NB; b++) begin
      rd(a_rise(b), d); chk("R1 rise reset", d, 0);
      rd(a_fall(b), d); chk("R1 fall reset", d, 0);
      rd(a_imsk(b), d); chk("R1 imsk reset", d, 0);
      rd(a_emsk(b), d); chk("R1 emsk reset", d, 0);
      rd(a_pend(b), d); chk("R1 pend reset", d, 0);
    end
    chk("R1 irq reset", {29'd0, irq_o}, 0);
    chk("R1 evt reset", (|evt_o) ? 32'd1 : 32'd0, 0);

    // R2 R3: probe availability through all-ones readback
    for (int b = 0; b < NB; b++) begin
      wr(a_rise(b), 32'hFFFF_FFFF);
      rd(a_rise(b), d); chk("R2 R3 probe rise", d, avail(b));
      wr(a_emsk(b), 32'hFFFF_FFFF);
      rd(a_emsk(b), d); chk("R3 probe emsk", d, avail(b));
      rd(a_fall(b), d); chk("R2 fall untouched", d, 0);
      wr(a_rise(b), 0);
      wr(a_emsk(b), 0);
    end

    // R4: rising edge on bank 0 line 3, latency of three edges
    wr(a_rise(0), 32'h0000_0008);
    @(negedge clk);
    ext_in[3] = 1'b1;
    m_pend[0] |= 32'h8;
    repeat (2) @(posedge clk);
    #1 chk("R4 not before third edge", u_edge_irq_ctrl.g_bank[0].u_bank.pend_q, 0);
    @(posedge clk);
    #1 chk("R4 pending at third edge", u_edge_irq_ctrl.g_bank[0].u_bank.pend_q, 32'h8);
    check_all("R4");

    // R6: fall on line 3 without falling enable, edge on line 5 without any enable
    v = ext_in; v[3] = 1'b0; v[5] = 1'b1;
    drive(v);
    check_all("R6");

    // R5: falling only, then both edges on bank 1 line 4
    wr(a_fall(1), 32'h0000_0010);
    v = ext_in; v[36] = 1'b1; drive(v);
    check_all("R5 rise ignored");
    v[36] = 1'b0; drive(v);
    check_all("R5 fall seen");
    wr(a_pend(1), 32'h10);
    wr(a_rise(1), 32'h0000_0010);
    v[36] = 1'b1; drive(v);
    check_all("R5 both rise");
    wr(a_pend(1), 32'h10);
    v[36] = 1'b0; drive(v);
    check_all("R5 both fall");

    // R7: zero write keeps bits, one write clears only its bit
    wr(a_swt(0), 32'h0000_0041);
    wr(a_pend(0), 32'h0);
    check_all("R7 zero write");
    wr(a_pend(0), 32'h0000_0001);
    check_all("R7 single clear");

    // R8: software trigger sets pending, reads zero, absent line stays clear
    wr(a_swt(1), 32'h0000_1080);
    rd(a_swt(1), d); chk("R8 swt reads zero", d, 0);
    check_all("R8 R3 swt");
    wr(a_swt(2), 32'h8000_0000);
    check_all("R3 swt absent bank2");

    // R9: interrupt mask gates the request
    wr(a_imsk(1), 32'h0000_0080);
    check_all("R9 masked on");
    wr(a_pend(1), 32'hFFFF_FFFF);
    check_all("R9 cleared");

    // R10: event pulse once per enabled edge with event mask
    wr(a_emsk(2), 32'h0000_0004);
    wr(a_rise(2), 32'h0000_0006);
    v = ext_in; v[66] = 1'b1; v[65] = 1'b1; drive(v);
    check_all("R10 event");

    // R11: unmapped addresses
    rd(8'h0C, d); chk("R11 gap 0x0C", d, 0);
    rd(8'h8C, d); chk("R11 gap 0x8C", d, 0);
    rd(8'h60, d); chk("R11 bank3 trig", d, 0);
    rd(8'hB0, d); chk("R11 bank3 mask", d, 0);
    rd(8'h02, d); chk("R11 unaligned", d, 0);
    rd(8'hC8, d); chk("R11 high window", d, 0);

    // random mix across R4 R5 R7 R9 R10
    for (int it = 0; it < 60; it++) begin
      int b, k;
      b = $urandom_range(NB - 1);
      k = $urandom_range(5);
      case (k)
        0: wr(a_rise(b), $urandom);
        1: wr(a_fall(b), $urandom);
        2: wr(a_imsk(b), $urandom);
        3: wr(a_emsk(b), $urandom);
        4: wr(a_swt(b), $urandom & $urandom);
        default: wr(a_pend(b), $urandom);
      endcase
      v = {$urandom, $urandom, $urandom};
      drive(v);
      check_all("R4 R5 R7 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule